// File: doc/BRIEF.md
# Page-Split Serial EEPROM Write Sequencer

This block writes a run of bytes into a two-wire serial EEPROM of 8192 bytes with 32-byte pages. A caller gives a start address, a byte count and a device select, then pulses `go`. The bytes arrive on a valid/ready stream. The block drives a byte-level transaction engine, which owns all bus timing. The block splits the run into bursts so that no burst crosses a page boundary. After each burst it waits for the device's internal write cycle to end by acknowledge polling. It then carries on at the next page until no bytes remain.

Each burst opens with a start and a header byte `{dev_sel[1:0], addr[12:8], 1'b0}` (bit 0 is the write flag). The low address byte follows, then the data bytes. A stop closes the burst. A poll attempt is a start plus the same header byte for the updated address. An acknowledge means the write has finished. A not-acknowledge means the device is still busy: the block sends a stop, waits `POLL_GAP` clocks and tries again. `MAX_POLLS` busy answers end the run with a timeout. A not-acknowledge on any header, address or data byte ends the run at once with a stop and a NACK error.

Engine command codes on `eng_op`: 1 = start then byte, 2 = byte, 3 = stop. `eng_req` stays high, with `eng_op` and `eng_byte` held, until the cycle in which `eng_done` is high. `eng_nack` is read in that cycle.

FSM states, in order of use:
- IDLE
- HDR_HI (header byte)
- HDR_LO (low address byte)
- DATA_WAIT (ready for the stream)
- DATA_SEND
- BURST_STOP
- POLL_GAP
- POLL_ADDR
- POLL_STOP
- ABORT_STOP
- FINISH (done pulse)

Transitions:
- IDLE→HDR_HI on `go` with a non-zero count. IDLE→FINISH on `go` with a zero count.
- HDR_HI→HDR_LO and HDR_LO→DATA_WAIT on an acknowledge. Either one goes to ABORT_STOP on a NACK.
- DATA_WAIT→DATA_SEND on `wd_valid`.
- DATA_SEND→DATA_WAIT, →BURST_STOP (page end or last byte) or →ABORT_STOP (NACK).
- BURST_STOP→POLL_GAP.
- POLL_GAP→POLL_ADDR after the gap.
- POLL_ADDR→POLL_STOP.
- POLL_STOP→HDR_HI (acknowledged, bytes remain), →FINISH (acknowledged with nothing left, or attempts spent), →POLL_GAP (busy).
- ABORT_STOP→FINISH.
- FINISH→IDLE.

Top module: `pgwr_seq`

## Requirements
- R1: A run opens with op 1 carrying `{dev_sel, addr[12:8], 0}`, then op 2 carrying `addr[7:0]`, where `addr` is the address of the burst's first byte.
- R2: Exactly `byte_count` bytes are taken from the stream, and each is sent as an op 2 in arrival order.
- R3: A burst closes with op 3 after the byte at a page offset of 31 or after the last byte. The address wraps from 8191 to 0.
- R4: The first poll attempt comes `POLL_GAP` clocks after the burst stop completes. Each retry comes `POLL_GAP` clocks after the preceding stop completes.
- R5: A busy poll is followed by op 3 and a retry. An acknowledged poll is followed by op 3, then either the next burst's header or completion.
- R6: After `MAX_POLLS` busy answers and their stop, the run ends with `done` and `err_timeout`.
- R7: A NACK on a header, address or data byte is followed by one op 3 and `done` with `err_nack`, and no further op.
- R8: `wd_ready` is high only while no engine command is pending, and no byte is taken between a burst stop and the next acknowledged poll.
- R9: `go` with a zero count gives `done` in the next cycle, with no engine op and no error.
- R10: While `eng_req` is high and `eng_done` is low, `eng_req`, `eng_op` and `eng_byte` hold in the next cycle.
- R11: After reset the block is idle: `busy`, `eng_req`, `wd_ready` and `done` are low.
- R12: `done` is high for exactly one cycle and is followed by idle. `busy` rises the cycle after `go` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken while idle |
| start_addr | input | 13 | First byte address |
| byte_count | input | 16 | Number of bytes to write |
| dev_sel | input | 2 | Device select bits placed in the header |
| wd_valid | input | 1 | Stream byte valid |
| wd_data | input | 8 | Stream byte |
| wd_ready | output | 1 | Stream byte accepted when high with valid |
| eng_req | output | 1 | Engine command pending |
| eng_op | output | 2 | Engine command code |
| eng_byte | output | 8 | Byte for the engine command |
| eng_done | input | 1 | Engine command complete |
| eng_nack | input | 1 | Byte not acknowledged, valid with done |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_nack | output | 1 | Run ended by a NACK, valid with done |
| err_timeout | output | 1 | Run ended by poll timeout, valid with done |

## Verification
Every result is tied to a clock edge. An engine op follows the `eng_done` edge of the previous op by one edge plus the engine latency. A poll attempt completes `POLL_GAP`+latency+1 edges after the previous stop completes. `done` is seen one edge after the final stop's completion edge, or one edge after a zero-count `go`. The bench's engine model stamps each op with the edge at which it completes, and those stamps are checked against the gap. Outputs are sampled on the falling edge, and the wait loops count falling edges so the zero-count latency is checked exactly.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ENG_NONE       = 2'd0,
        ENG_START_BYTE = 2'd1,
        ENG_BYTE       = 2'd2,
        ENG_STOP       = 2'd3
    } eng_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR_HI,
        S_HDR_LO,
        S_DATA_WAIT,
        S_DATA_SEND,
        S_BURST_STOP,
        S_POLL_GAP,
        S_POLL_ADDR,
        S_POLL_STOP,
        S_ABORT_STOP,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/pgwr_cursor.sv
// Address and remaining-count tracker; flags the last byte of a burst.
module pgwr_cursor #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  remain,
    output logic              burst_last,
    output logic              all_sent
);
    localparam logic [PAGE_W-1:0] PAGE_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= load_addr;
            remain <= load_cnt;
        end else if (step) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    assign burst_last = (addr[PAGE_W-1:0] == PAGE_TOP) || (remain == CNT_W'(1));
    assign all_sent   = (remain == '0);
endmodule

// File: rtl/pgwr_pacer.sv
// Inter-poll gap timer and busy-answer counter.
module pgwr_pacer #(
    parameter int POLL_GAP  = 25000,
    parameter int MAX_POLLS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_run,
    input  logic tries_clr,
    input  logic tries_bump,
    output logic gap_done,
    output logic tries_spent
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int TRY_W = $clog2(MAX_POLLS + 1);

    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !gap_run) gap_q <= '0;
        else                    gap_q <= gap_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || tries_clr) tries_q <= '0;
        else if (tries_bump)     tries_q <= tries_q + 1'b1;
    end

    assign gap_done    = gap_run && (gap_q == GAP_W'(POLL_GAP - 1));
    assign tries_spent = (tries_q == TRY_W'(MAX_POLLS));
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PAGE_W    = 5,
    parameter int CNT_W     = 16,
    parameter int POLL_GAP  = 25000,
    parameter int MAX_POLLS = 50,
    localparam int HI_W     = ADDR_W - 8,
    localparam int DEV_W    = 7 - HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic              wd_valid,
    input  logic [7:0]        wd_data,
    output logic              wd_ready,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_byte,
    input  logic              eng_done,
    input  logic              eng_nack,
    output logic              busy,
    output logic              done,
    output logic              err_nack,
    output logic              err_timeout
);
    seq_state_e state_q, state_d;

    logic [DEV_W-1:0]  dev_q;
    logic [7:0]        data_q;
    logic              poll_ok_q, nack_q, tmo_q;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  remain;
    logic              burst_last, all_sent, gap_done, tries_spent;
    logic              start_ok, ack_now, nack_now;
    logic [7:0]        hdr_byte;

    assign start_ok = (state_q == S_IDLE) && go;
    assign ack_now  = eng_done && !eng_nack;
    assign nack_now = eng_done && eng_nack;
    assign hdr_byte = {dev_q, addr[ADDR_W-1:8], 1'b0};

    pgwr_cursor #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .step       ((state_q == S_DATA_SEND) && ack_now),
        .load_addr  (start_addr),
        .load_cnt   (byte_count),
        .addr       (addr),
        .remain     (remain),
        .burst_last (burst_last),
        .all_sent   (all_sent)
    );

    pgwr_pacer #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .gap_run     (state_q == S_POLL_GAP),
        .tries_clr   ((state_q == S_BURST_STOP) && eng_done),
        .tries_bump  ((state_q == S_POLL_ADDR) && nack_now),
        .gap_done    (gap_done),
        .tries_spent (tries_spent)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (go) state_d = (byte_count == '0) ? S_FINISH : S_HDR_HI;
            S_HDR_HI:     if (eng_done) state_d = eng_nack ? S_ABORT_STOP : S_HDR_LO;
            S_HDR_LO:     if (eng_done) state_d = eng_nack ? S_ABORT_STOP : S_DATA_WAIT;
            S_DATA_WAIT:  if (wd_valid) state_d = S_DATA_SEND;
            S_DATA_SEND:  if (eng_done) state_d = eng_nack ? S_ABORT_STOP :
                                                  burst_last ? S_BURST_STOP : S_DATA_WAIT;
            S_BURST_STOP: if (eng_done) state_d = S_POLL_GAP;
            S_POLL_GAP:   if (gap_done) state_d = S_POLL_ADDR;
            S_POLL_ADDR:  if (eng_done) state_d = S_POLL_STOP;
            S_POLL_STOP:  if (eng_done) begin
                              if (poll_ok_q)        state_d = all_sent ? S_FINISH : S_HDR_HI;
                              else if (tries_spent) state_d = S_FINISH;
                              else                  state_d = S_POLL_GAP;
                          end
            S_ABORT_STOP: if (eng_done) state_d = S_FINISH;
            S_FINISH:     state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // Run-scoped registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q     <= '0;
            data_q    <= '0;
            poll_ok_q <= 1'b0;
            nack_q    <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            if (start_ok) begin
                dev_q  <= dev_sel;
                nack_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if ((state_q == S_DATA_WAIT) && wd_valid) data_q <= wd_data;
            if ((state_q == S_POLL_ADDR) && eng_done) poll_ok_q <= !eng_nack;
            if (nack_now && ((state_q == S_HDR_HI) || (state_q == S_HDR_LO) ||
                             (state_q == S_DATA_SEND)))
                nack_q <= 1'b1;
            if ((state_q == S_POLL_STOP) && eng_done && !poll_ok_q && tries_spent)
                tmo_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        eng_req     = 1'b0;
        eng_op      = ENG_NONE;
        eng_byte    = 8'h00;
        wd_ready    = 1'b0;
        done        = 1'b0;
        err_nack    = 1'b0;
        err_timeout = 1'b0;
        busy        = (state_q != S_IDLE);
        unique case (state_q)
            S_HDR_HI, S_POLL_ADDR: begin
                eng_req  = 1'b1;
                eng_op   = ENG_START_BYTE;
                eng_byte = hdr_byte;
            end
            S_HDR_LO: begin
                eng_req  = 1'b1;
                eng_op   = ENG_BYTE;
                eng_byte = addr[7:0];
            end
            S_DATA_SEND: begin
                eng_req  = 1'b1;
                eng_op   = ENG_BYTE;
                eng_byte = data_q;
            end
            S_BURST_STOP, S_POLL_STOP, S_ABORT_STOP: begin
                eng_req = 1'b1;
                eng_op  = ENG_STOP;
            end
            S_DATA_WAIT: wd_ready = 1'b1;
            S_FINISH: begin
                done        = 1'b1;
                err_nack    = nack_q;
                err_timeout = tmo_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic       err_nack,
    input logic       err_timeout,
    input logic       eng_req,
    input logic [1:0] eng_op,
    input logic [7:0] eng_byte,
    input logic       eng_done,
    input logic       wd_ready
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte)));

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready |-> !eng_req);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R12
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);

    // R6
    timeout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (done && !err_nack));

    // R7
    nack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_nack |-> done);

    // R11
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!eng_req && !wd_ready && !done));
endmodule

bind pgwr_seq pgwr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .busy        (busy),
    .done        (done),
    .err_nack    (err_nack),
    .err_timeout (err_timeout),
    .eng_req     (eng_req),
    .eng_op      (eng_op),
    .eng_byte    (eng_byte),
    .eng_done    (eng_done),
    .wd_ready    (wd_ready)
);

// File: tb/pgwr_seq_bench.sv
`timescale 1ns/1ps
module pgwr_seq_bench;
    localparam int GAP = 6;
    localparam int LAT = 3;
    localparam int MAXP = 50;
    localparam int LOGN = 512;

    // {addr[12:0], count[15:0], busy answers[15:0], dev[1:0]}
    localparam logic [46:0] VECS [0:5] = '{
        {13'h0000, 16'd1,  16'd0, 2'd1},
        {13'h0005, 16'd10, 16'd2, 2'd1},
        {13'h001E, 16'd5,  16'd1, 2'd2},
        {13'h0020, 16'd32, 16'd3, 2'd0},
        {13'h1FFE, 16'd5,  16'd0, 2'd3},
        {13'h01C5, 16'd70, 16'd1, 2'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
    logic [12:0] start_addr = '0;
    logic [15:0] byte_count = '0;
    logic [1:0]  dev_sel = '0;
    logic wd_valid, wd_ready, eng_req, eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0] wd_data, eng_byte;
    logic [1:0] eng_op;
    logic busy, done, err_nack, err_timeout;

    always #2 clk = ~clk;

    pgwr_seq #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_pgwr_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
        .byte_count(byte_count), .dev_sel(dev_sel), .wd_valid(wd_valid),
        .wd_data(wd_data), .wd_ready(wd_ready), .eng_req(eng_req),
        .eng_op(eng_op), .eng_byte(eng_byte), .eng_done(eng_done),
        .eng_nack(eng_nack), .busy(busy), .done(done), .err_nack(err_nack),
        .err_timeout(err_timeout)
    );

    int checks = 0, errors = 0;
    logic clr_log = 1'b0;
    int busy_cfg = 0, fail_idx = -1;

    // Engine model with op log
    logic [1:0] log_op [0:LOGN-1];
    logic [7:0] log_by [0:LOGN-1];
    int         log_t  [0:LOGN-1];
    int nlog = 0, lat = 0, busy_left = 0, mcyc = 0;
    logic [1:0] prev_op = 2'd0;
    logic in_poll = 1'b0;

    always @(posedge clk) begin
        mcyc     <= mcyc + 1;
        eng_done <= 1'b0;
        if (!rst_n || clr_log) begin
            lat <= 0; nlog <= 0; busy_left <= 0; prev_op <= 2'd0; in_poll <= 1'b0;
        end else if (eng_req && !eng_done) begin
            if (lat == LAT - 1) begin
                lat      <= 0;
                eng_done <= 1'b1;
                eng_nack <= (nlog == fail_idx) || (eng_op == 2'd1 && busy_left > 0);
                if (nlog < LOGN) begin
                    log_op[nlog] <= eng_op;
                    log_by[nlog] <= eng_byte;
                    log_t[nlog]  <= mcyc;
                end
                nlog    <= nlog + 1;
                prev_op <= eng_op;
                if (eng_op == 2'd1 && busy_left > 0) busy_left <= busy_left - 1;
                if (eng_op == 2'd1 && busy_left == 0) in_poll <= 1'b0;
                if (eng_op == 2'd3 && prev_op == 2'd2) begin
                    busy_left <= busy_cfg;
                    in_poll   <= 1'b1;
                end
            end else begin
                lat <= lat + 1;
            end
        end
    end

    // Stream source
    int src_k = 0, cyc = 0, poll_hs = 0, ready_bad = 0;
    assign wd_valid = (cyc % 3) != 2;
    assign wd_data  = src_k[7:0] ^ 8'h5A;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr_log) begin
            src_k <= 0; poll_hs <= 0; ready_bad <= 0;
        end else begin
            if (wd_valid && wd_ready) begin
                src_k <= src_k + 1;
                if (in_poll) poll_hs <= poll_hs + 1;
            end
            if (wd_ready && eng_req) ready_bad <= ready_bad + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected sequence built from the requirements
    logic [1:0] exp_op [0:LOGN-1];
    logic [7:0] exp_by [0:LOGN-1];
    int exp_kind [0:LOGN-1];
    int exp_n, exp_data, exp_err;
    bit halted, pushed;

    function automatic logic [7:0] hdr(input logic [1:0] d, input logic [12:0] a);
        return {d, a[12:8], 1'b0};
    endfunction

    task automatic push(input logic [1:0] op, input logic [7:0] by, input int kind);
        pushed = 1'b0;
        if (halted || exp_n >= LOGN - 1) return;
        exp_op[exp_n] = op; exp_by[exp_n] = by; exp_kind[exp_n] = kind;
        exp_n++;
        pushed = 1'b1;
        if (exp_n - 1 == fail_idx) begin
            exp_op[exp_n] = 2'd3; exp_by[exp_n] = 8'h00; exp_kind[exp_n] = 3;
            exp_n++;
            halted  = 1'b1;
            exp_err = 1;
        end
    endtask

    task automatic build(input logic [12:0] a0, input int cnt, input int bz, input logic [1:0] d);
        logic [12:0] a = a0;
        int rem = cnt, n;
        exp_n = 0; exp_data = 0; exp_err = 0; halted = 1'b0;
        while (rem > 0 && !halted) begin
            n = 32 - int'(a[4:0]);
            if (n > rem) n = rem;
            push(2'd1, hdr(d, a), 0);
            push(2'd2, a[7:0], 1);
            for (int j = 0; j < n; j++) begin
                push(2'd2, exp_data[7:0] ^ 8'h5A, 2);
                if (pushed) exp_data++;
            end
            a   = a + 13'(n);
            rem = rem - n;
            push(2'd3, 8'h00, 3);
            for (int k = 0; k < ((bz < MAXP) ? bz : MAXP); k++) begin
                push(2'd1, hdr(d, a), 4);
                push(2'd3, 8'h00, 3);
            end
            if (bz >= MAXP) begin
                if (!halted) exp_err = 2;
                halted = 1'b1;
            end else begin
                push(2'd1, hdr(d, a), 4);
                push(2'd3, 8'h00, 3);
            end
        end
    endtask

    int wait_cycles;

    task automatic run_case(input logic [12:0] a, input int cnt, input int bz,
                            input logic [1:0] d, input int fidx, input string tag);
        bit got = 1'b0;
        bit en = 1'b0, et = 1'b0;
        int mism = 0, gapbad = 0;
        busy_cfg = bz; fail_idx = fidx;
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
        build(a, cnt, bz, d);
        start_addr = a; byte_count = 16'(cnt); dev_sel = d; go = 1'b1;
        @(negedge clk); go = 1'b0;
        wait_cycles = 0;
        for (int k = 0; k < 20000 && !got; k++) begin
            if (done) begin
                got = 1'b1; en = err_nack; et = err_timeout;
            end else begin
                @(negedge clk);
                wait_cycles++;
            end
        end
        chk(got, {tag, " done seen"}, int'(got), 1);
        chk(en == (exp_err == 1), {tag, " R7 err_nack"}, int'(en), int'(exp_err == 1));
        chk(et == (exp_err == 2), {tag, " R6 err_timeout"}, int'(et), int'(exp_err == 2));
        @(negedge clk);
        chk(!done && !busy, {tag, " R12 done pulse then idle"}, int'(done || busy), 0);
        chk(nlog == exp_n, {tag, " R3 R5 op count"}, nlog, exp_n);
        for (int i = 0; i < exp_n && i < nlog; i++) begin
            if (log_op[i] != exp_op[i] || log_by[i] != exp_by[i]) mism++;
            if (exp_kind[i] == 4 && i > 0 && (log_t[i] - log_t[i-1]) != GAP + LAT + 1) gapbad++;
        end
        chk(mism == 0, {tag, " R1 R3 op sequence mismatches"}, mism, 0);
        chk(gapbad == 0, {tag, " R4 poll gap"}, gapbad, 0);
        chk(src_k == exp_data, {tag, " R2 bytes taken"}, src_k, exp_data);
        chk(poll_hs == 0 && ready_bad == 0, {tag, " R8 stall"}, poll_hs + ready_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !eng_req && !wd_ready && !done, "R11 reset quiet",
            int'(busy) + int'(eng_req) + int'(wd_ready) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !eng_req, "R11 idle after reset", int'(busy || eng_req), 0);

        for (int v = 0; v < 6; v++)
            run_case(VECS[v][46:34], int'(VECS[v][33:18]), int'(VECS[v][17:2]),
                     VECS[v][1:0], -1, "R1 R2 R3 R5 vector");

        // Directed corner cases
        run_case(13'h0040, 4, 0, 2'd1, 0, "R7 header nack");
        run_case(13'h0041, 4, 0, 2'd2, 1, "R7 address nack");
        run_case(13'h0010, 8, 0, 2'd1, 4, "R7 data nack");
        run_case(13'h0003, 3, 60, 2'd0, -1, "R6 poll timeout");
        run_case(13'h0003, 3, MAXP - 1, 2'd0, -1, "R5 last poll acknowledged");
        run_case(13'h0100, 0, 0, 2'd1, -1, "R9 zero count");
        chk(wait_cycles == 0, "R9 zero count latency", wait_cycles, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule